// File: doc/BRIEF.md
# Conditional 3×3 Median Filter with Incremental Ranks

This block filters a stream of 8-bit grayscale pixels through a 3×3 window. Each accepted beat brings one new three-pixel column into the window. The oldest column drops out of the block's own window registers. The six samples that stay do not get re-sorted. Instead, each one keeps a running rank that is adjusted by comparing it with the column entering and the column leaving. Each entering sample gets a fresh rank from comparisons with the remaining samples and with its column mates.

The block looks at the rank of the window's center sample. If that rank is at or above a high threshold, or at or below a low threshold, the output is the window median, which is the sample holding rank 5. Otherwise the center sample passes through untouched. This removes impulse noise and leaves fine detail alone. Setting both thresholds equal turns the block into a plain median filter. A typical setting is high = 8 and low = 2.

An upstream line buffer supplies one column per beat. Image border handling is left to the surroundings.

Top module: `cmf_filter`

## Requirements
- R1: After reset, `out_valid` stays low until a third column has been accepted. The result for an accepted column appears, with `out_valid` high for one cycle, five clock edges after the edge that accepted it.
- R2: `in_col` carries row 0 in bits [7:0], row 1 in [15:8] and row 2 in [23:16]. The window is made of the three most recently accepted columns. The center is row 1 of the middle column. From the third accepted column onward, every accepted column yields exactly one result, and results come out in acceptance order.
- R3: When the median is selected, the output equals the 5th smallest of the nine window values.
- R4: Samples are ranked 1 to 9 in a strict total order. The primary key is ascending value. Among equal values, a sample from a more recently accepted column ranks lower. Within one column, the lower row ranks lower. The output is the median when the center's rank is ≥ `thr_hi` or ≤ `thr_lo`; otherwise it is the center value.
- R5: With `thr_hi` equal to `thr_lo`, every output is the window median.
- R6: Cycles with `in_valid` low have no effect on the window, the ranks or the result sequence.
- R7: Equal values, including equal values entering in the same column, still receive distinct ranks under the R4 order, and the results stay correct.
- R8: With `thr_hi` = 10 and `thr_lo` = 0, no rank meets the condition, so every output is the center value.
- R9: The number of results equals the number of columns accepted after the second. No spurious result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New column present on `in_col` this cycle |
| in_col | input | 24 | Entering column, row 0 in the low byte |
| thr_hi | input | 4 | High rank threshold |
| thr_lo | input | 4 | Low rank threshold |
| out_valid | output | 1 | Result present on `out_pix` |
| out_pix | output | 8 | Filtered pixel |

## Verification
The assertions check four things on every cycle:
- the nine stored ranks always form a permutation of 1 to 9;
- the output select is one-hot whenever it is used;
- no result appears before three columns have been accepted;
- with equal thresholds, the select picks the sample holding rank 5.

Other behaviour can only be shown by the bench's scenarios against a model that sorts the whole window. This covers:
- the values produced;
- the tie order among equal values;
- the threshold decision across a sweep of threshold pairs;
- immunity to idle cycles;
- the exact latency and the result count.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  localparam int ROWS     = 3;
  localparam int COLS     = 3;
  localparam int NS       = ROWS * COLS;
  localparam int NREM     = NS - ROWS;
  localparam int RW       = $clog2(NS + 1);
  localparam int MID_RANK = (NS + 1) / 2;
  localparam int CENTER   = (COLS / 2) * ROWS + ROWS / 2;

  // number of set bits in a column-wide comparison word
  function automatic logic [1:0] ones3(input logic [ROWS-1:0] b);
    logic [1:0] n;
    n = '0;
    for (int i = 0; i < ROWS; i++) n = n + 2'(b[i]);
    return n;
  endfunction

  // number of set bits over the remaining samples
  function automatic logic [2:0] ones6(input logic [NREM-1:0] b);
    logic [2:0] n;
    n = '0;
    for (int i = 0; i < NREM; i++) n = n + 3'(b[i]);
    return n;
  endfunction

  // signed rank change, two's complement in 3 bits (-3..+3)
  function automatic logic [2:0] delta(input logic [1:0] up, input logic [1:0] down);
    return {1'b0, up} - {1'b0, down};
  endfunction

  function automatic logic [RW-1:0] adj_rank(input logic [RW-1:0] r, input logic [2:0] d);
    return r + {{(RW-3){d[2]}}, d};
  endfunction

  function automatic logic [RW-1:0] entry_rank(input logic [2:0] below_rem, input logic [1:0] below_in);
    return RW'(1) + RW'(below_rem) + RW'(below_in);
  endfunction
endpackage

// File: rtl/cmf_compare.sv
module cmf_compare import cmf_pkg::*; #(
  parameter int PW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc,
  input  logic                       elig,
  input  logic [NS-1:0][PW-1:0]      win,
  input  logic [ROWS-1:0][PW-1:0]    col,
  output logic                       s1_v,
  output logic                       s1_e,
  output logic [NREM-1:0][ROWS-1:0]  s1_ge,
  output logic [NREM-1:0][ROWS-1:0]  s1_gt,
  output logic [ROWS-1:0][ROWS-1:0]  s1_ee,
  output logic [NS-1:0][PW-1:0]      s1_win
);
  logic [NREM-1:0][ROWS-1:0] ge_c, gt_c;
  logic [ROWS-1:0][ROWS-1:0] ee_c;

  // remaining samples are old positions 0..NREM-1, leaving ones NREM..NS-1
  always_comb begin
    for (int k = 0; k < NREM; k++)
      for (int j = 0; j < ROWS; j++) begin
        ge_c[k][j] = win[k] >= col[j];
        gt_c[k][j] = win[k] >  win[NREM+j];
      end
    // ee_c[j][i]: entering row i is ordered below entering row j
    for (int j = 0; j < ROWS; j++)
      for (int i = 0; i < ROWS; i++)
        ee_c[j][i] = (i != j) && ((col[i] < col[j]) || ((col[i] == col[j]) && (i < j)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s1_e   <= 1'b0;
      s1_ge  <= '0;
      s1_gt  <= '0;
      s1_ee  <= '0;
      s1_win <= '0;
    end else begin
      s1_v <= acc;
      s1_e <= acc & elig;
      if (acc) begin
        s1_ge  <= ge_c;
        s1_gt  <= gt_c;
        s1_ee  <= ee_c;
        s1_win <= {win[NREM-1:0], col};
      end
    end
  end
endmodule

// File: rtl/cmf_rank.sv
module cmf_rank import cmf_pkg::*; #(
  parameter int PW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s1_v,
  input  logic                       s1_e,
  input  logic [NREM-1:0][ROWS-1:0]  s1_ge,
  input  logic [NREM-1:0][ROWS-1:0]  s1_gt,
  input  logic [ROWS-1:0][ROWS-1:0]  s1_ee,
  input  logic [NS-1:0][PW-1:0]      s1_win,
  output logic [NS-1:0][RW-1:0]      rank_q,
  output logic                       s4_e,
  output logic [NS-1:0][PW-1:0]      s4_win
);
  // stage 2: counting
  logic [NREM-1:0][1:0] inc_c, dec_c, s2_inc, s2_dec;
  logic [ROWS-1:0][NREM-1:0] lt_bits;
  logic [ROWS-1:0][2:0] nrem_c, s2_nrem;
  logic [ROWS-1:0][1:0] nin_c, s2_nin;
  logic s2_v, s2_e;
  logic [NS-1:0][PW-1:0] s2_win;

  always_comb begin
    for (int k = 0; k < NREM; k++) begin
      inc_c[k] = ones3(s1_ge[k]);
      dec_c[k] = ones3(s1_gt[k]);
    end
    for (int j = 0; j < ROWS; j++) begin
      for (int k = 0; k < NREM; k++) lt_bits[j][k] = ~s1_ge[k][j];
      nrem_c[j] = ones6(lt_bits[j]);
      nin_c[j]  = ones3(s1_ee[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_e <= 1'b0;
      s2_inc <= '0; s2_dec <= '0; s2_nrem <= '0; s2_nin <= '0; s2_win <= '0;
    end else begin
      s2_v <= s1_v;
      s2_e <= s1_v & s1_e;
      if (s1_v) begin
        s2_inc <= inc_c; s2_dec <= dec_c; s2_nrem <= nrem_c; s2_nin <= nin_c;
        s2_win <= s1_win;
      end
    end
  end

  // stage 3: combine adjustments, rank the entering samples
  logic [NREM-1:0][2:0] s3_d;
  logic [ROWS-1:0][RW-1:0] s3_new;
  logic s3_v, s3_e;
  logic [NS-1:0][PW-1:0] s3_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s3_v <= 1'b0; s3_e <= 1'b0; s3_d <= '0; s3_new <= '0; s3_win <= '0;
    end else begin
      s3_v <= s2_v;
      s3_e <= s2_v & s2_e;
      if (s2_v) begin
        for (int k = 0; k < NREM; k++) s3_d[k] <= delta(s2_inc[k], s2_dec[k]);
        for (int j = 0; j < ROWS; j++) s3_new[j] <= entry_rank(s2_nrem[j], s2_nin[j]);
        s3_win <= s2_win;
      end
    end
  end

  // stage 4: apply to the stored ranks (shifted with the window)
  logic [NS-1:0][RW-1:0] rank_nx;
  always_comb begin
    for (int p = 0; p < NS; p++)
      if (p < ROWS) rank_nx[p] = s3_new[p];
      else          rank_nx[p] = adj_rank(rank_q[p-ROWS], s3_d[p-ROWS]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      // all-zero window: newer column and lower row rank lower
      for (int p = 0; p < NS; p++) rank_q[p] <= RW'(p + 1);
      s4_e   <= 1'b0;
      s4_win <= '0;
    end else begin
      s4_e <= s3_v & s3_e;
      if (s3_v) begin
        rank_q <= rank_nx;
        s4_win <= s3_win;
      end
    end
  end
endmodule

// File: rtl/cmf_select.sv
module cmf_select import cmf_pkg::*; #(
  parameter int PW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NS-1:0][RW-1:0]  rank_q,
  input  logic                   s4_e,
  input  logic [NS-1:0][PW-1:0]  s4_win,
  input  logic [RW-1:0]          thr_hi,
  input  logic [RW-1:0]          thr_lo,
  output logic [NS-1:0]          sel5,
  output logic                   sel5_v,
  output logic                   out_valid,
  output logic [PW-1:0]          out_pix
);
  logic [NS-1:0] med_oh, sel_c;
  logic use_med;
  logic [NS-1:0][PW-1:0] s5_win;
  logic [PW-1:0] mux_c;

  // stage 5: decode
  always_comb begin
    for (int p = 0; p < NS; p++) med_oh[p] = rank_q[p] == RW'(MID_RANK);
    use_med = (rank_q[CENTER] >= thr_hi) || (rank_q[CENTER] <= thr_lo);
    sel_c   = use_med ? med_oh : NS'(1) << CENTER;
  end

  // stage 6: multiplex
  always_comb begin
    mux_c = '0;
    for (int p = 0; p < NS; p++)
      if (sel5[p]) mux_c = mux_c | s5_win[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel5 <= '0; sel5_v <= 1'b0; s5_win <= '0;
      out_valid <= 1'b0; out_pix <= '0;
    end else begin
      sel5_v <= s4_e;
      if (s4_e) begin
        sel5   <= sel_c;
        s5_win <= s4_win;
      end
      out_valid <= sel5_v;
      if (sel5_v) out_pix <= mux_c;
    end
  end
endmodule

// File: rtl/cmf_filter.sv
module cmf_filter import cmf_pkg::*; #(
  parameter int PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [ROWS*PIX_W-1:0]   in_col,
  input  logic [RW-1:0]           thr_hi,
  input  logic [RW-1:0]           thr_lo,
  output logic                    out_valid,
  output logic [PIX_W-1:0]        out_pix
);
  localparam logic [1:0] FILL_LAST = 2'(COLS - 1);

  logic [ROWS-1:0][PIX_W-1:0] col;
  logic [NS-1:0][PIX_W-1:0]   win;
  logic [1:0]                 fill;
  logic                       elig;

  assign col  = in_col;
  assign elig = (fill == FILL_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win  <= '0;
      fill <= '0;
    end else if (in_valid) begin
      win <= {win[NREM-1:0], col};
      if (!elig) fill <= fill + 2'd1;
    end
  end

  logic                       s1_v, s1_e;
  logic [NREM-1:0][ROWS-1:0]  s1_ge, s1_gt;
  logic [ROWS-1:0][ROWS-1:0]  s1_ee;
  logic [NS-1:0][PIX_W-1:0]   s1_win;

  cmf_compare #(.PW(PIX_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .acc(in_valid), .elig(elig), .win(win), .col(col),
    .s1_v(s1_v), .s1_e(s1_e), .s1_ge(s1_ge), .s1_gt(s1_gt), .s1_ee(s1_ee), .s1_win(s1_win)
  );

  logic [NS-1:0][RW-1:0]      rank_q;
  logic                       s4_e;
  logic [NS-1:0][PIX_W-1:0]   s4_win;

  cmf_rank #(.PW(PIX_W)) u_rank (
    .clk(clk), .rst_n(rst_n), .s1_v(s1_v), .s1_e(s1_e), .s1_ge(s1_ge), .s1_gt(s1_gt),
    .s1_ee(s1_ee), .s1_win(s1_win), .rank_q(rank_q), .s4_e(s4_e), .s4_win(s4_win)
  );

  logic [NS-1:0] sel5;
  logic          sel5_v;

  cmf_select #(.PW(PIX_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .rank_q(rank_q), .s4_e(s4_e), .s4_win(s4_win),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .sel5(sel5), .sel5_v(sel5_v),
    .out_valid(out_valid), .out_pix(out_pix)
  );
endmodule

// File: rtl/cmf_chk.sv
module cmf_chk import cmf_pkg::*; (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic [NS-1:0][RW-1:0] ranks,
  input logic [NS-1:0]         sel,
  input logic                  sel_v,
  input logic [RW-1:0]         thr_hi,
  input logic [RW-1:0]         thr_lo
);
  localparam int OCC_W = 2 ** RW;
  localparam logic [OCC_W-1:0] FULL = OCC_W'(((1 << NS) - 1) << 1);

  logic [OCC_W-1:0] occ;
  logic [NS-1:0]    mid_oh;
  logic [1:0]       seen;

  always_comb begin
    occ = '0;
    for (int p = 0; p < NS; p++) occ[ranks[p]] = 1'b1;
    for (int p = 0; p < NS; p++) mid_oh[p] = ranks[p] == RW'(MID_RANK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && seen != 2'd3) seen <= seen + 2'd1;
  end

  // R4 / R7: ranks stay a permutation of 1..9
  a_r4_rank_perm: assert property (@(posedge clk) disable iff (!rst_n) occ == FULL);

  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    sel_v |-> $countones(sel) == 1);

  a_r1_no_early_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen == 2'd3);

  a_r5_equal_thr_median: assert property (@(posedge clk) disable iff (!rst_n)
    sel_v && $past(thr_hi == thr_lo) |-> sel == $past(mid_oh));
endmodule

bind cmf_filter cmf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .ranks(rank_q), .sel(sel5), .sel_v(sel5_v), .thr_hi(thr_hi), .thr_lo(thr_lo)
);

// File: tb/sim_cmf_filter.sv
`timescale 1ns/100ps
module sim_cmf_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [23:0] in_col = '0;
  logic [3:0] thr_hi = 4'd8, thr_lo = 4'd2;
  logic out_valid;
  logic [7:0] out_pix;

  always #2.5 clk = ~clk;

  cmf_filter u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_col(in_col),
                 .thr_hi(thr_hi), .thr_lo(thr_lo), .out_valid(out_valid), .out_pix(out_pix));

  int n_chk = 0, n_fail = 0, n_out = 0, n_push = 0;
  int mw[9];
  int filled = 0;
  int exp_q[$];
  string tag_q[$];
  string cur_tag = "R2";
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference: full ordering of the window, position p = column*3 + row, column 0 newest
  function automatic int ref_pix(input int hi, input int lo, output bit med);
    int cr, m;
    cr = 1; m = 0;
    for (int q = 0; q < 9; q++)
      if (q != 4 && (mw[q] < mw[4] || (mw[q] == mw[4] && q < 4))) cr++;
    for (int q = 0; q < 9; q++) begin
      int lt, le;
      lt = 0; le = 0;
      for (int t = 0; t < 9; t++) begin
        if (mw[t] < mw[q]) lt++;
        if (mw[t] <= mw[q]) le++;
      end
      if (lt <= 4 && le >= 5) m = mw[q];
    end
    med = (cr >= hi) || (cr <= lo);
    return med ? m : mw[4];
  endfunction

  task automatic send(input int a, input int b, input int c);
    bit med;
    int e;
    @(negedge clk);
    in_valid = 1'b1;
    in_col = {8'(c), 8'(b), 8'(a)};
    for (int p = 8; p >= 3; p--) mw[p] = mw[p-3];
    mw[0] = a; mw[1] = b; mw[2] = c;
    filled++;
    if (filled >= 3) begin
      e = ref_pix(int'(thr_hi), int'(thr_lo), med);
      exp_q.push_back(e);
      tag_q.push_back((cur_tag == "R2" && med) ? "R3" : cur_tag);
      n_push++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic send_rand(input int range);
    send(int'($urandom_range(range)), int'($urandom_range(range)), int'($urandom_range(range)));
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R9", int'(out_pix), -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(out_pix) == e, t, int'(out_pix), e);
        n_out++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 9; p++) mw[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset", int'(out_valid), 0);

    // R1: fill and latency
    cur_tag = "R1";
    send(10, 200, 30);
    send(40, 50, 60);
    send(70, 80, 90);
    idle(1);
    for (int i = 0; i < 5; i++) begin
      chk(out_valid == 1'b0, "R1 latency", int'(out_valid), 0);
      @(negedge clk);
    end
    chk(out_valid == 1'b1, "R1 latency", int'(out_valid), 1);
    idle(8);

    // R2/R3: dense random stream, typical thresholds
    cur_tag = "R2";
    for (int i = 0; i < 40; i++) send_rand(255);
    idle(8);

    // R4/R5: sweep over threshold pairs
    for (int hi = 1; hi <= 9; hi++)
      for (int lo = 0; lo <= hi; lo++) begin
        thr_hi = 4'(hi); thr_lo = 4'(lo);
        cur_tag = (hi == lo) ? "R5" : "R4";
        for (int i = 0; i < 8; i++) send_rand(((hi + lo) % 2 == 0) ? 255 : 3);
        idle(8);
      end

    // R6: idle gaps between columns
    thr_hi = 4'd8; thr_lo = 4'd2;
    cur_tag = "R6";
    for (int i = 0; i < 30; i++) begin
      send_rand(255);
      idle(int'($urandom_range(3)));
    end
    idle(8);

    // R7: heavy ties, including whole columns of one value
    thr_hi = 4'd6; thr_lo = 4'd4;
    cur_tag = "R7";
    for (int i = 0; i < 40; i++) begin
      if (i % 3 == 0) begin
        int v;
        v = 5 + int'($urandom_range(2));
        send(v, v, v);
      end else send(5 + int'($urandom_range(2)), 5 + int'($urandom_range(2)), 5 + int'($urandom_range(2)));
    end
    idle(8);

    // R8: thresholds outside the rank range
    thr_hi = 4'd10; thr_lo = 4'd0;
    cur_tag = "R8";
    for (int i = 0; i < 20; i++) send_rand(255);
    idle(10);

    // R9: result count
    chk(exp_q.size() == 0 && n_out == n_push, "R9 count", n_out, n_push);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule